// File: doc/BRIEF.md
# Word Memory with Transforming Write Locations

This block is a small synchronous single-port memory of 15-bit words. It has one address, a write enable, write data and registered read data. Most locations are ordinary storage. Four consecutive locations change each word on its way into storage, so software can rotate or shift a value just by storing it and reading it back:

| Octal address | Transform applied on write |
|---|---|
| 0020 | rotate left by one |
| 0021 | rotate right by one |
| 0022 | arithmetic shift right by one |
| 0023 | logical shift right by seven |

Octal location 0007 is a constant-zero location. Writes to it are accepted and thrown away, and it always reads as zero. This gives a cheap way to clear a register through an ordinary load.

The transform is applied only once, when the word is written. After that the location holds the result like any other word, so reading it again returns the same value. Reset clears every word to zero.

Top module: `xform_mem`

## Requirements
- R1: A write to any address other than octal 0007, 0020, 0021, 0022 or 0023 stores the word unchanged, and a later read of that address returns it.
- R2: A write to octal 0020 stores the word rotated left by one over all 15 bits: stored[k] = data[k-1] for k = 1..14, and stored[0] = data[14].
- R3: A write to octal 0021 stores the word rotated right by one over all 15 bits: stored[k] = data[k+1] for k = 0..13, and stored[14] = data[0].
- R4: A write to octal 0022 stores an arithmetic right shift by one: stored[12:0] = data[13:1], and both stored[14] and stored[13] equal data[14].
- R5: A write to octal 0023 stores the word shifted right by seven with zero fill: stored[7:0] = data[14:7], and stored[14:8] = 0.
- R6: Octal address 0007 always reads as zero. A write to it has no effect on its read value, and it leaves octal 0006 and 0010 unchanged.
- R7: A transformed location returns its stored result on every read, without transforming it again.
- R8: Read data is registered. `rd_data` shows the word at the address presented one clock earlier. In a write cycle, the next `rd_data` is the newly stored (transformed) value.
- R9: While `rst_n` is low, every word is cleared to zero and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array and the read register |
| addr | input | 10 | Word address for the read or the write |
| wr_en | input | 1 | High to write `wr_data` (after its transform) at `addr` |
| wr_data | input | 15 | Word to store |
| rd_data | output | 15 | Registered read data for the address of the previous cycle |

## Verification
The assertions take for granted that `addr`, `wr_en` and `wr_data` are known (not X or Z) at every rising edge while reset is released. They also assume that reset changes only between transactions, so that each implication covers a single clean write cycle. The stimulus meets these conditions. It changes inputs only on the falling edge, holds `wr_en` low with a defined address during and around each reset, and applies one write or read per cycle.

// File: rtl/xform_mem.sv
`timescale 1ns/1ps
module xform_mem #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 15,
  parameter int LSR_AMT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ZERO_LOC = ADDR_W'('o7);
  localparam logic [ADDR_W-1:0] ROL_LOC  = ADDR_W'('o20);
  localparam logic [ADDR_W-1:0] ROR_LOC  = ADDR_W'('o21);
  localparam logic [ADDR_W-1:0] ASR_LOC  = ADDR_W'('o22);
  localparam logic [ADDR_W-1:0] LSR_LOC  = ADDR_W'('o23);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] store_val;
  logic              is_zero;

  assign is_zero = (addr == ZERO_LOC);

  always_comb begin
    case (addr)
      ROL_LOC: store_val = {wr_data[DATA_W-2:0], wr_data[DATA_W-1]};
      ROR_LOC: store_val = {wr_data[0], wr_data[DATA_W-1:1]};
      ASR_LOC: store_val = {wr_data[DATA_W-1], wr_data[DATA_W-1:1]};
      LSR_LOC: store_val = wr_data >> LSR_AMT;
      default: store_val = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && !is_zero) mem[addr] <= store_val;
      if (is_zero)    rd_data <= '0;
      else if (wr_en) rd_data <= store_val;
      else            rd_data <= mem[addr];
    end
  end

  // R1
  plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_zero && addr != ROL_LOC && addr != ROR_LOC && addr != ASR_LOC && addr != LSR_LOC)
    |=> rd_data == $past(wr_data));

  // R2
  rol_xform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ROL_LOC) |=> (rd_data[0] == $past(wr_data[DATA_W-1]) &&
                                    rd_data[DATA_W-1:1] == $past(wr_data[DATA_W-2:0])));

  // R3
  ror_xform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ROR_LOC) |=> (rd_data[DATA_W-1] == $past(wr_data[0]) &&
                                    rd_data[DATA_W-2:0] == $past(wr_data[DATA_W-1:1])));

  // R4
  asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ASR_LOC) |=> (rd_data[DATA_W-1] == rd_data[DATA_W-2] &&
                                    rd_data[DATA_W-1] == $past(wr_data[DATA_W-1])));

  // R5
  lsr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LSR_LOC) |=> (rd_data[DATA_W-1:DATA_W-LSR_AMT] == '0 &&
                                    rd_data[DATA_W-LSR_AMT-1:0] == $past(wr_data[DATA_W-1:LSR_AMT])));

  // R6
  zero_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_zero |=> rd_data == '0);

  // R7
  no_retransform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en) && addr == $past(addr) && $past(rst_n)) |=> $stable(rd_data));
endmodule

// File: tb/xform_mem_test.sv
`timescale 1ns/1ps
module xform_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_data = '0;
  logic [14:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  xform_mem uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                 .wr_data(wr_data), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {10'o20,   15'h4001, 15'h0003},
    {10'o20,   15'h1234, 15'h2468},
    {10'o21,   15'h0001, 15'h4000},
    {10'o21,   15'h2468, 15'h1234},
    {10'o22,   15'h4000, 15'h6000},
    {10'o22,   15'h7FFE, 15'h7FFF},
    {10'o22,   15'h2AAA, 15'h1555},
    {10'o23,   15'h7FFF, 15'h00FF},
    {10'o23,   15'h3F80, 15'h007F},
    {10'o7,    15'h7FFF, 15'h0000},
    {10'd0,    15'h5555, 15'h5555},
    {10'd1023, 15'h2AAA, 15'h2AAA},
    {10'o24,   15'h1234, 15'h1234},
    {10'o17,   15'h7FFF, 15'h7FFF},
    {10'o6,    15'h0F0F, 15'h0F0F}
  };

  function automatic string tag_of(input logic [9:0] a);
    case (a)
      10'o20:  return "R2";
      10'o21:  return "R3";
      10'o22:  return "R4";
      10'o23:  return "R5";
      10'o7:   return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [9:0] a, input logic we, input logic [14:0] d);
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: rd_data=%h expected=done", rd_data);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset holds rd_data at zero
    check("R9", rd_data, 15'h0);
    rst_n = 1'b1;
    // R9: words read zero after reset
    cyc(10'd0, 1'b0, '0);    check("R9", rd_data, 15'h0);
    cyc(10'o20, 1'b0, '0);   check("R9", rd_data, 15'h0);
    cyc(10'd1023, 1'b0, '0); check("R9", rd_data, 15'h0);

    // table: R8 write-cycle result, then R7 reread unchanged
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][39:30], 1'b1, VEC[i][29:15]);
      check(tag_of(VEC[i][39:30]), rd_data, VEC[i][14:0]);
      cyc(VEC[i][39:30], 1'b0, '0);
      check("R7", rd_data, VEC[i][14:0]);
    end

    // R7: many rereads of a rotated word stay the same
    cyc(10'o20, 1'b1, 15'h0001);
    for (int k = 0; k < 3; k++) begin
      cyc(10'o20, 1'b0, '0);
      check("R7", rd_data, 15'h0002);
    end

    // R6: neighbours around zero location untouched
    cyc(10'o10, 1'b1, 15'h3333);
    cyc(10'o7, 1'b1, 15'h1111);
    cyc(10'o6, 1'b0, '0);  check("R6", rd_data, 15'h0F0F);
    cyc(10'o10, 1'b0, '0); check("R6", rd_data, 15'h3333);
    cyc(10'o7, 1'b0, '0);  check("R6", rd_data, 15'h0000);

    // R8: read right after a write sees new value; plain word follows address
    cyc(10'd500, 1'b1, 15'h6A5C);
    cyc(10'd501, 1'b1, 15'h0101);
    cyc(10'd500, 1'b0, '0); check("R8", rd_data, 15'h6A5C);
    cyc(10'd501, 1'b0, '0); check("R8", rd_data, 15'h0101);
    // R8: output holds old address value until next edge
    @(negedge clk); addr = 10'd500; wr_en = 1'b0;
    #1 check("R8", rd_data, 15'h0101);
    @(posedge clk); #1 check("R8", rd_data, 15'h6A5C);

    // R9: second reset clears written words
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(10'd0, 1'b0, '0);   check("R9", rd_data, 15'h0);
    cyc(10'o23, 1'b0, '0);  check("R9", rd_data, 15'h0);
    cyc(10'd500, 1'b0, '0); check("R9", rd_data, 15'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule